// File: doc/BRIEF.md
# Prioritised Interrupt Flag Controller

This block collects interrupt requests from five hardware sources into a flag register. It keeps a separate 8-bit enable register and reports to the CPU the one source that is both flagged and enabled and has the highest fixed priority. Each source raises its flag with a single-cycle request pulse. The CPU clears a serviced flag with a per-source acknowledge. Both registers sit on a simple byte-wide register bus with a combinational read port.

The pending-source output is one-hot, or all zero when nothing is pending. It is derived combinationally from the registered flag and enable values. The block leaves to the CPU side the decision to take the interrupt, the vector jump and any halt wake-up.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register reads 0xE0, the enable register reads 0x00 and `pend_o` is 0.
- R2: A write to address 0xFFFF stores all 8 data bits into the enable register, and a read of 0xFFFF returns them unchanged.
- R3: A write to address 0xFF0F keeps only data bits [4:0] as the flags. A read of 0xFF0F returns the flags with bits [7:5] forced to 1.
- R4: Source bit positions are fixed: bit 0 vertical blank, bit 1 LCD status, bit 2 timer, bit 3 serial, bit 4 joypad. A request pulse on `req_i[k]` sets flag bit k at the next clock edge and leaves the other flag bits as they were.
- R5: An acknowledge on `ack_i[k]` clears only flag bit k at the next clock edge. With no request, acknowledge or flag write, the flags hold.
- R6: `pend_o` is the lowest-numbered bit of (flags AND enable[4:0]), which is the highest priority, as a one-hot vector. It is zero when that AND is zero.
- R7: When several flag updates coincide in one cycle, they apply in this order. A CPU flag write comes first. Acknowledges then clear their bits. Hardware requests are then ORed on last, so a request wins over both a write and an acknowledge of the same bit.
- R8: A read of any other address returns 0xFF. A write to any other address changes neither register.
- R9: Enable bits [7:5] are stored but never make a source pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 5 | Per-source request pulses (bit order per R4) |
| ack_i | input | 5 | Per-source acknowledge from the CPU |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| pend_o | output | 5 | One-hot highest-priority pending source, or zero |

## Verification
On every cycle the assertions check several properties. A request sets its own flag bit, and an acknowledge that no request overrides clears its bit. The flags hold when nothing touches them, and an enable write lands whole. `pend_o` stays one-hot or zero, is a subset of the flagged and enabled bits, and is nonzero whenever anything is pending. Only the bench scenarios can show the rest. These are the exact read-back encodings with the forced top flag bits, the ordering of a flag write, acknowledge and request that land in the same cycle, and the absence of effect from foreign addresses. The priority choice among several flagged sources and the inertness of enable bits [7:5] also rest on the scenarios.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_NSRC  = 5;
  localparam int BUS_AW    = 16;
  localparam int BUS_DW    = 8;
  localparam logic [BUS_AW-1:0] FLAG_REG_ADDR = 16'hFF0F;
  localparam logic [BUS_AW-1:0] EN_REG_ADDR   = 16'hFFFF;
  localparam logic [BUS_DW-1:0] OPEN_BUS_VAL  = 8'hFF;

  // Source positions, lowest index is highest priority
  typedef enum int unsigned {
    SRC_VBLANK = 0,
    SRC_LCD    = 1,
    SRC_TIMER  = 2,
    SRC_SERIAL = 3,
    SRC_JOYPAD = 4
  } irq_src_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_val,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] flag_q
);
  logic [NSRC-1:0] flag_d;
  logic            flag_ce;

  // Write first, then acknowledge clears, then hardware sets win
  always_comb begin
    flag_d  = wr_en ? wr_val : flag_q;
    flag_d  = flag_d & ~clr_vec;
    flag_d  = flag_d | set_vec;
    flag_ce = wr_en | (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] en_q
);
  logic [DW-1:0] en_d;

  always_comb begin
    en_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0] active_i,
  output logic [NSRC-1:0] grant_o
);
  // blocked[i] is set when any lower-index (higher priority) source is active
  logic [NSRC:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    assign grant_o[i]    = active_i[i] & ~blocked[i];
    assign blocked[i+1]  = blocked[i] | active_i[i];
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int                NSRC      = IRQ_NSRC,
  parameter int                AW        = BUS_AW,
  parameter int                DW        = BUS_DW,
  parameter logic [AW-1:0]     FLAG_ADDR = FLAG_REG_ADDR,
  parameter logic [AW-1:0]     EN_ADDR   = EN_REG_ADDR,
  parameter logic [DW-1:0]     OPEN_BUS  = OPEN_BUS_VAL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] ack_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NSRC-1:0] pend_o
);
  localparam int FILL_W = DW - NSRC;

  logic            rst_n_sync;
  logic            flag_sel;
  logic            en_sel;
  logic            flag_wr_s;
  logic            en_wr_s;
  logic [NSRC-1:0] flag_q;
  logic [DW-1:0]   en_q;
  logic [NSRC-1:0] active_s;

  irq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    flag_sel  = (bus_addr == FLAG_ADDR);
    en_sel    = (bus_addr == EN_ADDR);
    flag_wr_s = bus_wr & flag_sel;
    en_wr_s   = bus_wr & en_sel;
  end

  irq_flag_reg #(.NSRC(NSRC)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (flag_wr_s),
    .wr_val  (bus_wdata[NSRC-1:0]),
    .set_vec (req_i),
    .clr_vec (ack_i),
    .flag_q  (flag_q)
  );

  irq_en_reg #(.DW(DW)) u_en (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_en  (en_wr_s),
    .wr_val (bus_wdata),
    .en_q   (en_q)
  );

  assign active_s = flag_q & en_q[NSRC-1:0];

  irq_prio_sel #(.NSRC(NSRC)) u_prio (
    .active_i (active_s),
    .grant_o  (pend_o)
  );

  always_comb begin
    if (flag_sel) begin
      bus_rdata = {{FILL_W{1'b1}}, flag_q};
    end else if (en_sel) begin
      bus_rdata = en_q;
    end else begin
      bus_rdata = OPEN_BUS;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_i,
  input logic [NSRC-1:0] ack_i,
  input logic            flag_wr,
  input logic            en_wr,
  input logic [DW-1:0]   wdata,
  input logic [NSRC-1:0] flag_q,
  input logic [DW-1:0]   en_q,
  input logic [NSRC-1:0] pend_o
);
  // R4
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> ((flag_q & $past(req_i)) == $past(req_i)));

  // R5
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_i != '0) && !flag_wr) |=> ((flag_q & $past(ack_i & ~req_i)) == '0));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && (req_i == '0) && (ack_i == '0)) |=> $stable(flag_q));

  // R2
  en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(wdata)));

  // R6
  pend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_o));

  // R6
  pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~(flag_q & en_q[NSRC-1:0])) == '0));

  // R6
  pend_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q[NSRC-1:0]) != '0) |-> (pend_o != '0));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .req_i   (req_i),
  .ack_i   (ack_i),
  .flag_wr (flag_wr_s),
  .en_wr   (en_wr_s),
  .wdata   (bus_wdata),
  .flag_q  (flag_q),
  .en_q    (en_q),
  .pend_o  (pend_o)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
  localparam logic [15:0] A_FLAG  = 16'hFF0F;
  localparam logic [15:0] A_EN    = 16'hFFFF;
  localparam logic [15:0] A_OTHER = 16'hFF0E;

  typedef struct {
    logic [7:0] exp_rd;
    logic [4:0] exp_pend;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  req_i;
  logic [4:0]  ack_i;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [4:0]  pend_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  exp_t sb_q[$];

  logic [4:0] m_flag;
  logic [7:0] m_en;

  always #2.5 clk = ~clk;

  irq_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pend_o(pend_o)
  );

  function automatic logic [4:0] model_pend(logic [4:0] f, logic [7:0] e);
    logic [4:0] act;
    act = f & e[4:0];
    for (int i = 0; i < 5; i++) begin
      if (act[i]) return 5'(1 << i);
    end
    return 5'd0;
  endfunction

  // One bus/request cycle; the model follows the requirements
  task automatic step(input logic wr, input logic [15:0] a, input logic [7:0] d,
                      input logic [4:0] rq, input logic [4:0] ak);
    logic [4:0] nf;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; req_i = rq; ack_i = ak;
    nf = (wr && a == A_FLAG) ? d[4:0] : m_flag;
    nf = (nf & ~ak) | rq;
    if (wr && a == A_EN) m_en = d;
    m_flag = nf;
    @(negedge clk);
    bus_wr = 1'b0; req_i = '0; ack_i = '0;
  endtask

  // Driver side of the scoreboard: present a read and push the expectation
  task automatic expect_rd(input logic [15:0] a, input string tag);
    exp_t it;
    bus_addr = a;
    if (a == A_FLAG)    it.exp_rd = {3'b111, m_flag};
    else if (a == A_EN) it.exp_rd = m_en;
    else                it.exp_rd = 8'hFF;
    it.exp_pend = model_pend(m_flag, m_en);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp_rd || pend_o !== it.exp_pend) begin
          errors++;
          $display("FAIL %s: rdata=%02h pend=%05b expected rdata=%02h pend=%05b",
                   it.tag, bus_rdata, pend_o, it.exp_rd, it.exp_pend);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: expired expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = '0; ack_i = '0; bus_addr = A_OTHER; bus_wr = 1'b0; bus_wdata = '0;
    m_flag = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    expect_rd(A_FLAG, "R1 flag reset");
    expect_rd(A_EN,   "R1 enable reset");

    step(1, A_EN, 8'hFF, 0, 0);   expect_rd(A_EN, "R2 enable all ones");
    step(1, A_EN, 8'hA5, 0, 0);   expect_rd(A_EN, "R2 enable pattern");
    step(1, A_FLAG, 8'hFF, 0, 0); expect_rd(A_FLAG, "R3 flag write masked");
    step(1, A_FLAG, 8'h40, 0, 0); expect_rd(A_FLAG, "R3 flag upper bits dropped");

    step(1, A_EN, 8'h1F, 0, 0);
    step(0, A_OTHER, 0, 5'h10, 0); expect_rd(A_FLAG, "R4 joypad request");
    step(0, A_OTHER, 0, 5'h04, 0); expect_rd(A_FLAG, "R4 timer request keeps joypad R6");
    step(0, A_OTHER, 0, 5'h01, 0); expect_rd(A_FLAG, "R4 vblank request R6 top priority");
    step(0, A_OTHER, 0, 5'h02, 0); expect_rd(A_FLAG, "R4 lcd request R6 vblank still wins");
    step(0, A_OTHER, 0, 0, 5'h01); expect_rd(A_FLAG, "R5 ack vblank R6 lcd next");
    step(0, A_OTHER, 0, 0, 5'h06); expect_rd(A_FLAG, "R5 ack lcd and timer");
    step(0, A_OTHER, 0, 5'h08, 0); expect_rd(A_FLAG, "R4 serial request R6");
    step(1, A_EN, 8'h07, 0, 0);    expect_rd(A_FLAG, "R6 disabled sources not pending");
    step(1, A_FLAG, 8'h1F, 0, 0);  expect_rd(A_FLAG, "R6 vblank enabled wins");
    step(1, A_EN, 8'hE0, 0, 0);    expect_rd(A_EN, "R9 upper enable bits only");
    expect_rd(A_FLAG, "R9 no pending from upper enable bits");

    step(1, A_EN, 8'h1F, 0, 0);
    step(1, A_FLAG, 8'h02, 5'h08, 0); expect_rd(A_FLAG, "R7 request ORed onto write");
    step(0, A_OTHER, 0, 5'h01, 5'h01); expect_rd(A_FLAG, "R7 request beats ack");
    step(1, A_FLAG, 8'h13, 0, 5'h01); expect_rd(A_FLAG, "R7 ack after write");
    step(1, A_FLAG, 8'h00, 5'h04, 5'h04); expect_rd(A_FLAG, "R7 request beats write and ack");

    step(1, A_OTHER, 8'h00, 0, 0); expect_rd(A_FLAG, "R8 foreign write leaves flags");
    expect_rd(A_EN,    "R8 foreign write leaves enable");
    expect_rd(A_OTHER, "R8 foreign read open bus");
    expect_rd(16'h0000, "R8 low address read");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule